// File: doc/BRIEF.md
# Indirect Prefetch Table with Confidence

This block watches the load stream of a core and learns two kinds of regular access. For each load instruction, keyed by its program counter, it keeps one table entry. The entry notices when the load walks memory one cache line at a time and then asks for the next few lines. It also handles loads that read an index `k` which later drives an access to `base + (k << shift)`, the `A[B[i]]` pattern. Once a separate pattern detector supplies `base` and `shift`, the entry predicts the addresses of the next few index values.

The table is set-associative. The set comes from PC bits `[2 +: log2(SETS)]`, the full PC serves as the tag, and replacement within a set is least-recently-used. Each entry carries two confidence counters. The stream counter grows with each line-sequential access from the same security region. The indirect counter grows when the cache sees the address predicted from the current index, and it shrinks when the index moves on and no such access was seen. Prefetch addresses leave one at a time on a valid/ready port.

When a load allocates an entry, or gives a new index to an entry that has not been taught yet, the table sends a single-cycle request carrying the PC and index to the pattern detector. The detector later answers with the PC, base and shift.

Top module: `ipt_top`

## Requirements
- R1: While reset is high and on the first cycle after it, `pf_valid` and `det_req_valid` are low, and every entry is empty, so the first observation of any PC allocates.
- R2: An observation registers `det_req_valid` for exactly one cycle, with that PC and index, in the cycle after it is sampled, in two cases. One is when the observation allocates an entry. The other is when it changes the index of an entry that is not yet enabled. An enabled entry never raises a request.
- R3: On an observation that hits, the stream counter increments, saturating at `2^SCNT_W-1`, when the address equals the stored address plus `LINE_BYTES` and the security flag is unchanged. Otherwise the counter clears. Once the updated counter is at least `STREAM_THR`, a burst of `min(STREAM_DIST, MAX_DIST)` addresses `addr + j*LINE_BYTES`, `j = 1, 2, ...`, is started.
- R4: A detector response whose PC is present enables that entry, loads its base and shift, clears its indirect counter and clears its matched flag.
- R5: A cache access whose address equals `base + (index << shift)` of an enabled entry sets that entry's matched flag and increments its indirect counter, which saturates at `IND_MAX`.
- R6: When an observation changes an entry's index and the matched flag is clear, the indirect counter decrements but never goes below zero. The matched flag is then cleared.
- R7: When an enabled entry's index changes to `n` and the updated indirect counter is at least `IND_THR`, a burst of `min(IND_DIST, MAX_DIST)` addresses `base + ((n+j) << shift)`, `j = 1, 2, ...`, is started. If the stream rule fires on the same observation, only this burst starts.
- R8: While `pf_valid` is high and `pf_ready` is low, `pf_valid` stays high and `pf_addr` holds. A burst advances one address per handshake.
- R9: A burst is started only when no burst is in progress. A trigger that arrives while one is active is dropped.
- R10: When a set is full, an allocation evicts the way touched least recently by an observation.
- R11: An observation that repeats the stored index leaves the indirect counter unchanged, raises no request and starts no indirect burst.
- R12: A burst is loaded at the clock edge that samples its triggering observation, so `pf_valid` rises one cycle after that observation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| obs_valid | input | 1 | Load observation present |
| obs_pc | input | PC_W | PC of the observed load |
| obs_addr | input | ADDR_W | Address the load accessed |
| obs_secure | input | 1 | Security-region flag of the access |
| obs_index | input | IDX_W | Value the load returned, used as an index |
| acc_valid | input | 1 | Cache access present |
| acc_addr | input | ADDR_W | Cache access address |
| det_rsp_valid | input | 1 | Pattern detector answer present |
| det_rsp_pc | input | PC_W | PC the answer belongs to |
| det_rsp_base | input | ADDR_W | Learned base address |
| det_rsp_shift | input | SHIFT_W | Learned shift amount |
| det_req_valid | output | 1 | Request toward the pattern detector |
| det_req_pc | output | PC_W | PC of the request |
| det_req_index | output | IDX_W | Index carried by the request |
| pf_valid | output | 1 | Prefetch address available |
| pf_ready | input | 1 | Consumer takes the prefetch address |
| pf_addr | output | ADDR_W | Prefetch address |

## Verification
Indirect prediction is swept over shift values 0 to 3 with a fresh index each time. This separates a wrong shift, a wrong base offset or a wrong index step from correct address arithmetic. Counter behaviour is probed through the burst/no-burst boundary at the threshold. The patterns used are matched and unmatched index changes, repeated indices, a long run of matches that exposes the saturation point, and a run of misses that exposes any wrap below zero. Stream detection is tried with sequential, security-flipped and non-sequential addresses. Backpressure is combined with a second trigger, which distinguishes holding from dropping. Three PCs share one set and show which way LRU replacement evicts.

// File: rtl/ipt_pkg.sv
package ipt_pkg;
  typedef enum logic [1:0] {
    EV_NONE     = 2'd0,
    EV_STREAM   = 2'd1,
    EV_INDIRECT = 2'd2
  } ipt_ev_e;
endpackage

// File: rtl/ipt_lru.sv
module ipt_lru #(
  parameter int SETS  = 4,
  parameter int WAYS  = 2,
  parameter int SET_W = 2,
  parameter int WAY_W = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             touch,
  input  logic [SET_W-1:0] touch_set,
  input  logic [WAY_W-1:0] touch_way,
  input  logic [SET_W-1:0] look_set,
  output logic [WAY_W-1:0] victim
);
  // age 0 = most recent, WAYS-1 = oldest; each set keeps a permutation
  logic [WAY_W-1:0] age [SETS][WAYS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          age[s][w] <= WAY_W'(w);
    end else if (touch) begin
      for (int w = 0; w < WAYS; w++) begin
        if (WAY_W'(w) == touch_way)
          age[touch_set][w] <= '0;
        else if (age[touch_set][w] < age[touch_set][touch_way])
          age[touch_set][w] <= age[touch_set][w] + 1'b1;
      end
    end
  end

  always_comb begin
    victim = '0;
    for (int w = 0; w < WAYS; w++)
      if (age[look_set][w] == WAY_W'(WAYS - 1)) victim = WAY_W'(w);
  end
endmodule

// File: rtl/ipt_burst.sv
module ipt_burst #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [ADDR_W-1:0] step,
  input  logic [LEN_W-1:0]  len,
  input  logic              ready,
  output logic              valid,
  output logic [ADDR_W-1:0] addr
);
  logic [ADDR_W-1:0] step_q;
  logic [LEN_W-1:0]  left_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid  <= 1'b0;
      addr   <= '0;
      step_q <= '0;
      left_q <= '0;
    end else if (!valid) begin
      if (start && len != '0) begin
        valid  <= 1'b1;
        addr   <= start_addr;
        step_q <= step;
        left_q <= len;
      end
    end else if (ready) begin
      if (left_q == LEN_W'(1)) valid <= 1'b0;
      left_q <= left_q - 1'b1;
      addr   <= addr + step_q;
    end
  end
endmodule

// File: rtl/ipt_top.sv
module ipt_top
  import ipt_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int PC_W        = 16,
  parameter int IDX_W       = 16,
  parameter int SHIFT_W     = 3,
  parameter int SETS        = 4,
  parameter int WAYS        = 2,
  parameter int LINE_BYTES  = 64,
  parameter int SCNT_W      = 2,
  parameter int STREAM_THR  = 2,
  parameter int STREAM_DIST = 2,
  parameter int ICNT_W      = 3,
  parameter int IND_MAX     = 5,
  parameter int IND_THR     = 2,
  parameter int IND_DIST    = 4,
  parameter int MAX_DIST    = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               obs_valid,
  input  logic [PC_W-1:0]    obs_pc,
  input  logic [ADDR_W-1:0]  obs_addr,
  input  logic               obs_secure,
  input  logic [IDX_W-1:0]   obs_index,
  input  logic               acc_valid,
  input  logic [ADDR_W-1:0]  acc_addr,
  input  logic               det_rsp_valid,
  input  logic [PC_W-1:0]    det_rsp_pc,
  input  logic [ADDR_W-1:0]  det_rsp_base,
  input  logic [SHIFT_W-1:0] det_rsp_shift,
  output logic               det_req_valid,
  output logic [PC_W-1:0]    det_req_pc,
  output logic [IDX_W-1:0]   det_req_index,
  output logic               pf_valid,
  input  logic               pf_ready,
  output logic [ADDR_W-1:0]  pf_addr
);
  localparam int SET_W  = $clog2(SETS);
  localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam int NENT   = SETS * WAYS;
  localparam int ENT_W  = $clog2(NENT);
  localparam int LEN_W  = $clog2(MAX_DIST + 1);
  localparam logic [SCNT_W-1:0] SCNT_TOP = '1;
  localparam logic [SCNT_W-1:0] S_THR    = SCNT_W'(STREAM_THR);
  localparam logic [ICNT_W-1:0] I_TOP    = ICNT_W'(IND_MAX);
  localparam logic [ICNT_W-1:0] I_THR    = ICNT_W'(IND_THR);
  localparam logic [LEN_W-1:0]  S_LEN    = LEN_W'((STREAM_DIST < MAX_DIST) ? STREAM_DIST : MAX_DIST);
  localparam logic [LEN_W-1:0]  I_LEN    = LEN_W'((IND_DIST < MAX_DIST) ? IND_DIST : MAX_DIST);
  localparam logic [ADDR_W-1:0] LINE     = ADDR_W'(LINE_BYTES);

  typedef struct packed {
    logic               valid;
    logic [PC_W-1:0]    pc;
    logic [ADDR_W-1:0]  last;
    logic               sec;
    logic [SCNT_W-1:0]  scnt;
    logic               en;
    logic [IDX_W-1:0]   idx;
    logic [ADDR_W-1:0]  base;
    logic [SHIFT_W-1:0] sh;
    logic [ICNT_W-1:0]  icnt;
    logic               seen;
  } ent_t;

  function automatic logic [ADDR_W-1:0] target(input logic [ADDR_W-1:0] b,
                                               input logic [ADDR_W-1:0] k,
                                               input logic [SHIFT_W-1:0] s);
    return b + (k << s);
  endfunction

  ent_t tbl [NENT];
  ent_t nxt [NENT];

  // ---- set lookup for observation and detector answer ----
  logic [SET_W-1:0] oset, rset;
  logic             ohit, ofree, rhit;
  logic [WAY_W-1:0] oway_hit, oway_free, oway, rway, lru_way;
  logic [ENT_W-1:0] otgt, rtgt;

  assign oset = obs_pc[2 +: SET_W];
  assign rset = det_rsp_pc[2 +: SET_W];

  always_comb begin
    ohit = 1'b0; ofree = 1'b0; rhit = 1'b0;
    oway_hit = '0; oway_free = '0; rway = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (tbl[int'(oset) * WAYS + w].valid && tbl[int'(oset) * WAYS + w].pc == obs_pc) begin
        ohit = 1'b1; oway_hit = WAY_W'(w);
      end
      if (!tbl[int'(oset) * WAYS + w].valid) begin
        ofree = 1'b1; oway_free = WAY_W'(w);
      end
      if (tbl[int'(rset) * WAYS + w].valid && tbl[int'(rset) * WAYS + w].pc == det_rsp_pc) begin
        rhit = 1'b1; rway = WAY_W'(w);
      end
    end
    oway = ohit ? oway_hit : (ofree ? oway_free : lru_way);
    otgt = ENT_W'(oset) * ENT_W'(WAYS) + ENT_W'(oway);
    rtgt = ENT_W'(rset) * ENT_W'(WAYS) + ENT_W'(rway);
  end

  ipt_lru #(.SETS(SETS), .WAYS(WAYS), .SET_W(SET_W), .WAY_W(WAY_W)) u_lru (
    .clk(clk), .rst(rst), .touch(obs_valid), .touch_set(oset),
    .touch_way(oway), .look_set(oset), .victim(lru_way)
  );

  // ---- next state: cache access first, then observation, then answer ----
  ipt_ev_e          ev;
  logic             req_fire;
  logic [ADDR_W-1:0] ev_addr, ev_step;
  logic [LEN_W-1:0]  ev_len;

  always_comb begin
    ent_t n;
    logic str_hit, ind_hit;
    ev = EV_NONE;
    req_fire = 1'b0;
    ev_addr = '0; ev_step = '0; ev_len = '0;
    for (int e = 0; e < NENT; e++) begin
      n = tbl[e];
      str_hit = 1'b0;
      ind_hit = 1'b0;
      if (acc_valid && n.en && acc_addr == target(n.base, ADDR_W'(n.idx), n.sh)) begin
        if (n.icnt != I_TOP) n.icnt = n.icnt + 1'b1;
        n.seen = 1'b1;
      end
      if (obs_valid && ENT_W'(e) == otgt) begin
        if (!ohit) begin
          n       = '0;
          n.valid = 1'b1;
          n.pc    = obs_pc;
          n.last  = obs_addr;
          n.sec   = obs_secure;
          n.idx   = obs_index;
          req_fire = 1'b1;
        end else begin
          if (obs_addr == n.last + LINE && obs_secure == n.sec) begin
            if (n.scnt != SCNT_TOP) n.scnt = n.scnt + 1'b1;
          end else begin
            n.scnt = '0;
          end
          n.last = obs_addr;
          n.sec  = obs_secure;
          str_hit = (n.scnt >= S_THR);
          if (obs_index != n.idx) begin
            if (!n.seen && n.icnt != '0) n.icnt = n.icnt - 1'b1;
            n.seen = 1'b0;
            n.idx  = obs_index;
            if (n.en) ind_hit = (n.icnt >= I_THR);
            else      req_fire = 1'b1;
          end
        end
        if (ind_hit) begin
          ev      = EV_INDIRECT;
          ev_addr = target(n.base, ADDR_W'(n.idx) + 1'b1, n.sh);
          ev_step = ADDR_W'(1) << n.sh;
          ev_len  = I_LEN;
        end else if (str_hit) begin
          ev      = EV_STREAM;
          ev_addr = obs_addr + LINE;
          ev_step = LINE;
          ev_len  = S_LEN;
        end
      end
      if (det_rsp_valid && rhit && ENT_W'(e) == rtgt) begin
        n.en   = 1'b1;
        n.base = det_rsp_base;
        n.sh   = det_rsp_shift;
        n.icnt = '0;
        n.seen = 1'b0;
      end
      nxt[e] = n;
    end
  end

  always_ff @(posedge clk) begin
    for (int e = 0; e < NENT; e++) begin
      if (rst) tbl[e] <= '0;
      else     tbl[e] <= nxt[e];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      det_req_valid <= 1'b0;
      det_req_pc    <= '0;
      det_req_index <= '0;
    end else begin
      det_req_valid <= req_fire;
      det_req_pc    <= obs_pc;
      det_req_index <= obs_index;
    end
  end

  ipt_burst #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_burst (
    .clk(clk), .rst(rst), .start(ev != EV_NONE), .start_addr(ev_addr),
    .step(ev_step), .len(ev_len), .ready(pf_ready), .valid(pf_valid),
    .addr(pf_addr)
  );
endmodule

// File: rtl/ipt_chk.sv
module ipt_chk #(
  parameter int ADDR_W   = 32,
  parameter int MAX_DIST = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              obs_valid,
  input logic              det_req_valid,
  input logic              pf_valid,
  input logic              pf_ready,
  input logic [ADDR_W-1:0] pf_addr
);
  int unsigned taken;

  always_ff @(posedge clk) begin
    if (rst || !pf_valid) taken <= 0;
    else if (pf_ready)    taken <= taken + 1;
  end

  AST_RESET_QUIET: assert property (@(posedge clk) $past(rst) |-> (!pf_valid && !det_req_valid)); // R1
  AST_REQ_CAUSE: assert property (@(posedge clk) disable iff (rst) det_req_valid |-> $past(obs_valid)); // R2
  AST_PF_HOLD: assert property (@(posedge clk) disable iff (rst) (pf_valid && !pf_ready) |=> (pf_valid && $stable(pf_addr))); // R8
  AST_BURST_LEN: assert property (@(posedge clk) disable iff (rst) pf_valid |-> (taken < MAX_DIST)); // R7
  AST_BURST_CAUSE: assert property (@(posedge clk) disable iff (rst) $rose(pf_valid) |-> $past(obs_valid)); // R12
endmodule

bind ipt_top ipt_chk #(.ADDR_W(ADDR_W), .MAX_DIST(MAX_DIST)) u_chk (
  .clk(clk), .rst(rst), .obs_valid(obs_valid), .det_req_valid(det_req_valid),
  .pf_valid(pf_valid), .pf_ready(pf_ready), .pf_addr(pf_addr)
);

// File: tb/test_ipt_top.sv
module test_ipt_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        obs_valid = 1'b0;
  logic [15:0] obs_pc = '0;
  logic [31:0] obs_addr = '0;
  logic        obs_secure = 1'b0;
  logic [15:0] obs_index = '0;
  logic        acc_valid = 1'b0;
  logic [31:0] acc_addr = '0;
  logic        det_rsp_valid = 1'b0;
  logic [15:0] det_rsp_pc = '0;
  logic [31:0] det_rsp_base = '0;
  logic [2:0]  det_rsp_shift = '0;
  logic        det_req_valid;
  logic [15:0] det_req_pc;
  logic [15:0] det_req_index;
  logic        pf_valid;
  logic        pf_ready = 1'b1;
  logic [31:0] pf_addr;

  always #4 clk = ~clk;

  ipt_top i_ipt_top (
    .clk(clk), .rst(rst), .obs_valid(obs_valid), .obs_pc(obs_pc),
    .obs_addr(obs_addr), .obs_secure(obs_secure), .obs_index(obs_index),
    .acc_valid(acc_valid), .acc_addr(acc_addr), .det_rsp_valid(det_rsp_valid),
    .det_rsp_pc(det_rsp_pc), .det_rsp_base(det_rsp_base),
    .det_rsp_shift(det_rsp_shift), .det_req_valid(det_req_valid),
    .det_req_pc(det_req_pc), .det_req_index(det_req_index),
    .pf_valid(pf_valid), .pf_ready(pf_ready), .pf_addr(pf_addr)
  );

  localparam int LINE = 64;
  localparam int SLEN = 2;
  localparam int ILEN = 3;

  int checks = 0;
  int fails  = 0;
  int reqs   = 0;
  logic [15:0] rq_pc, rq_idx;
  logic [31:0] cap [$];

  always @(negedge clk) begin
    if (!rst) begin
      if (pf_valid && pf_ready) cap.push_back(pf_addr);
      if (det_req_valid) begin
        reqs++;
        rq_pc  = det_req_pc;
        rq_idx = det_req_index;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic obs(input logic [15:0] pc, input logic [31:0] a, input logic s, input logic [15:0] k);
    obs_valid = 1'b1; obs_pc = pc; obs_addr = a; obs_secure = s; obs_index = k;
    tick();
    obs_valid = 1'b0;
    idle(8);
  endtask

  task automatic acc(input logic [31:0] a);
    acc_valid = 1'b1; acc_addr = a;
    tick();
    acc_valid = 1'b0;
  endtask

  task automatic rsp(input logic [15:0] pc, input logic [31:0] b, input logic [2:0] s);
    det_rsp_valid = 1'b1; det_rsp_pc = pc; det_rsp_base = b; det_rsp_shift = s;
    tick();
    det_rsp_valid = 1'b0;
  endtask

  task automatic burst(input string tag, input logic [31:0] first, input logic [31:0] stp, input int n);
    check(cap.size() == n, tag, cap.size(), n);
    for (int i = 0; i < n && i < cap.size(); i++)
      check(cap[i] == first + stp * i, tag, cap[i], first + stp * i);
    cap.delete();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] P, Q, A, B, C;
    logic [31:0] base;
    int c;
    int r0;
    P = 16'h0104; Q = 16'h0208;
    A = 16'h0010; B = 16'h0020; C = 16'h0030;
    base = 32'h0000_8000;

    idle(4);
    #1;
    check(!pf_valid, "R1 pf_valid in reset", pf_valid, 0);
    rst = 1'b0;
    tick();
    check(!pf_valid && !det_req_valid, "R1 outputs after reset", {pf_valid, det_req_valid}, 0);

    // R2 allocation request
    obs(P, 32'h1000, 0, 16'h0011);
    check(reqs == 1, "R2 alloc request count", reqs, 1);
    check(rq_pc == P && rq_idx == 16'h0011, "R2 request fields", {rq_pc, rq_idx}, {P, 16'h0011});
    burst("R2 no burst on alloc", 0, 0, 0);

    // R3 stream detection
    obs(P, 32'h1040, 0, 16'h0011);
    burst("R3 below threshold", 0, 0, 0);
    obs(P, 32'h1080, 0, 16'h0011);
    burst("R3 threshold burst", 32'h10C0, LINE, SLEN);
    obs(P, 32'h10C0, 0, 16'h0011);
    burst("R3 saturating burst", 32'h1100, LINE, SLEN);
    obs(P, 32'h1100, 1, 16'h0011);
    burst("R3 secure flip clears", 0, 0, 0);
    obs(P, 32'h1140, 1, 16'h0011);
    burst("R3 restart count", 0, 0, 0);
    obs(P, 32'h1180, 1, 16'h0011);
    burst("R3 restart burst", 32'h11C0, LINE, SLEN);
    obs(P, 32'h5000, 1, 16'h0011);
    burst("R3 non-sequential", 0, 0, 0);
    check(reqs == 1, "R11 repeated index no request", reqs, 1);

    // R4/R7: enabled entry with zero confidence
    c = 5;
    obs(Q, 32'h9000, 0, 16'(c));
    check(reqs == 2, "R2 second alloc", reqs, 2);
    obs(Q, 32'h9000, 0, 16'(c + 1));
    c = c + 1;
    check(reqs == 3, "R2 index change on disabled entry", reqs, 3);
    check(rq_idx == 16'(c), "R2 new index carried", rq_idx, c);
    rsp(Q, base, 0);
    obs(Q, 32'h9000, 0, 16'(c + 1));
    c = c + 1;
    burst("R4 enabled but no confidence", 0, 0, 0);
    check(reqs == 3, "R2 enabled entry no request", reqs, 3);

    // R5/R6/R7 sweep over shift
    for (int s = 0; s < 4; s++) begin
      rsp(Q, base + 32'(s) * 32'h100, 3'(s));
      acc(base + 32'(s) * 32'h100 + (32'(c) << s));
      acc(base + 32'(s) * 32'h100 + (32'(c) << s));
      idle(2);
      obs(Q, 32'h9000, 0, 16'(c + 7));
      c = c + 7;
      burst("R7 indirect burst", base + 32'(s) * 32'h100 + (32'(c + 1) << s), 32'(1) << s, ILEN);
      obs(Q, 32'h9000, 0, 16'(c));
      burst("R11 same index no burst", 0, 0, 0);
      obs(Q, 32'h9000, 0, 16'(c + 1));
      c = c + 1;
      burst("R6 unmatched change decrements", 0, 0, 0);
    end

    // R6 floor at zero (counter is 1 here)
    obs(Q, 32'h9000, 0, 16'(c + 1)); c = c + 1;
    obs(Q, 32'h9000, 0, 16'(c + 1)); c = c + 1;
    burst("R6 stays at zero", 0, 0, 0);
    acc(base + 32'h300 + (32'(c) << 3));
    idle(2);
    obs(Q, 32'h9000, 0, 16'(c + 1)); c = c + 1;
    burst("R6 no wrap below zero", 0, 0, 0);

    // R5 saturation at IND_MAX = 5: bursts at counts 5,4,3,2 then none
    rsp(Q, base, 2);
    for (int i = 0; i < 7; i++) acc(base + (32'(c) << 2));
    idle(2);
    for (int i = 0; i < 5; i++) begin
      obs(Q, 32'h9000, 0, 16'(c + 1));
      c = c + 1;
      if (i < 4) burst("R5 saturated counter burst", base + (32'(c + 1) << 2), 4, ILEN);
      else       burst("R5 saturation limit", 0, 0, 0);
    end

    // R7 priority over stream on the same observation
    rsp(Q, base, 1);
    obs(Q, 32'hA000, 0, 16'(c));
    obs(Q, 32'hA040, 0, 16'(c));
    obs(Q, 32'hA080, 0, 16'(c));
    burst("R3 stream on indirect entry", 32'hA0C0, LINE, SLEN);
    acc(base + (32'(c) << 1));
    acc(base + (32'(c) << 1));
    idle(2);
    obs(Q, 32'hA0C0, 0, 16'(c + 3));
    c = c + 3;
    burst("R7 indirect wins over stream", base + (32'(c + 1) << 1), 2, ILEN);

    // R8/R9/R12 backpressure and dropped trigger
    rsp(Q, base, 2);
    acc(base + (32'(c) << 2));
    acc(base + (32'(c) << 2));
    idle(2);
    pf_ready = 1'b0;
    obs_valid = 1'b1; obs_pc = Q; obs_addr = 32'h9000; obs_secure = 0; obs_index = 16'(c + 1);
    tick();
    obs_valid = 1'b0;
    c = c + 1;
    check(pf_valid, "R12 valid one cycle after trigger", pf_valid, 1);
    check(pf_addr == base + (32'(c + 1) << 2), "R8 first address", pf_addr, base + (32'(c + 1) << 2));
    obs(P, 32'h5040, 1, 16'h0011);
    obs(P, 32'h5080, 1, 16'h0011);
    check(pf_valid && pf_addr == base + (32'(c + 1) << 2), "R8 held under backpressure", pf_addr, base + (32'(c + 1) << 2));
    pf_ready = 1'b1;
    idle(8);
    burst("R9 only first burst delivered", base + (32'(c + 1) << 2), 4, ILEN);
    obs(P, 32'h50C0, 1, 16'h0011);
    burst("R9 stream resumes", 32'h5100, LINE, SLEN);

    // R10 LRU in set 0
    r0 = reqs;
    obs(A, 32'h100, 0, 16'h1);
    obs(B, 32'h200, 0, 16'h2);
    obs(A, 32'h100, 0, 16'h1);
    obs(C, 32'h300, 0, 16'h3);
    check(reqs == r0 + 3, "R10 three allocations", reqs, r0 + 3);
    obs(A, 32'h100, 0, 16'h1);
    check(reqs == r0 + 3, "R10 recent way kept", reqs, r0 + 3);
    obs(B, 32'h200, 0, 16'h2);
    check(reqs == r0 + 4, "R10 least recent way evicted", reqs, r0 + 4);
    check(rq_pc == B, "R10 evicted PC reallocated", rq_pc, B);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule